// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-visible side of an I2C master. A 32-bit register port lets a host set up a transfer: the command word with enable, address-size, direction, combined-mode and interrupt-enable flags, a 10-bit target address split over two registers, two clock dividers, and two FIFO configuration words. One data register feeds a 16-byte transmit FIFO when written and drains a 16-byte receive FIFO when read. A separate bus engine, not part of this block, drives SCL and SDA. It pops transmit bytes, pushes received bytes and reports completion or a missing acknowledge.

A small transaction state machine sequences each transfer. In `ST_IDLE` it waits for a command write that sets the start bit together with the master-enable bit. That write takes it to `ST_LAUNCH`, which lasts one cycle and raises the engine start pulse. It then moves to `ST_BUSY`. From `ST_LAUNCH` or `ST_BUSY`, any done or not-acknowledged event returns it to `ST_IDLE`. On that return it records the event in the status register and clears the start bit. A level interrupt is raised while interrupts are enabled and any status flag is set. Software acknowledges it by writing status bit 7.

Top module: `i2c_reg_frontend`

## Requirements
- R1: After reset every register reads 0, both FIFOs are empty, `irq` is low and `eng_start` is low.
- R2: The register offsets are as follows, and every other offset reads 0. Command is at 0x04, using bits 0, 1, 3, 4 and 5. The high address is at 0x0C and keeps 3 bits. The low address is at 0x10 and keeps 7 bits. The fast divider is at 0x14 and the high-speed divider at 0x18, each keeping 16 bits. `eng_addr` is {high[2:0], low[6:0]}.
- R3: A write to offset 0x24 pushes bits 7:0 into the 16-entry transmit FIFO. The engine reads bytes in order on `eng_tx_data` and takes each one with `eng_tx_pop`. A push into a full transmit FIFO is dropped.
- R4: `eng_rx_push` stores `eng_rx_data` in the 16-entry receive FIFO, and a push into a full receive FIFO is dropped. A read of offset 0x24 returns the oldest byte and removes it. When the FIFO is empty, a read returns 0 and changes nothing.
- R5: Writing 1 to bit 7 of offset 0x1C empties the transmit FIFO. Writing 1 to bit 7 of offset 0x20 empties the receive FIFO. Bit 7 always reads 0, and bits 3:0 of both registers are kept.
- R6: Bits 3:0 of offset 0x20 hold the read byte count minus one and drive `eng_rd_count`.
- R7: A command write with bit 6 and bit 0 both set, made while idle, raises `eng_start` for exactly the one cycle after the write. Command bit 6 then reads 1 until the transfer ends. Bit 6 written without bit 0 neither starts a transfer nor is stored.
- R8: During a transfer, `eng_done` sets status bit 0, `eng_nak_addr` sets bit 1 and `eng_nak_data` sets bit 2, and the event ends the transfer, clearing command bit 6. Events that arrive while idle are ignored.
- R9: Writing status (0x28) with bit 7 set clears status bits 2:0. An event arriving in the same cycle still sets its flag.
- R10: `irq` is high exactly when command bit 3 is set and any status bit 2:0 is set.
- R11: `eng_ten_bit`, `eng_read` and `eng_combined` follow command bits 1, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x24) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle transfer start pulse |
| eng_read | output | 1 | Transfer direction is read |
| eng_combined | output | 1 | Combined write-then-read transfer |
| eng_ten_bit | output | 1 | 10-bit target addressing |
| eng_addr | output | 10 | Target address |
| eng_div_fast | output | 16 | Fast-mode clock divider |
| eng_div_hs | output | 16 | High-speed clock divider |
| eng_rd_count | output | 4 | Bytes to read minus one |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_push | input | 1 | Engine stores one received byte |
| eng_rx_full | output | 1 | Receive FIFO full |
| eng_done | input | 1 | Transfer completed |
| eng_nak_addr | input | 1 | Target address not acknowledged |
| eng_nak_data | input | 1 | Data byte not acknowledged |

## Verification
The assertions check on every cycle that the start pulse lasts one cycle and follows a legal launch write. They also check that an accepted event returns the state machine to idle and clears the start bit, that an acknowledge without a competing event zeroes the status, and that the FIFOs never exceed depth, drop pushes when full, ignore pops when empty and are empty after a flush. Only the bench scenarios can show byte order through both FIFOs, the field masks of each register, and that events are ignored while idle. They also show that a flush keeps the configuration bits, the interrupt combination and the priority of an event over an acknowledge in the same cycle.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_CMD     = 8'h04;
    localparam logic [REG_AW-1:0] OFF_ADDR_HI = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_ADDR_LO = 8'h10;
    localparam logic [REG_AW-1:0] OFF_DIV_FS  = 8'h14;
    localparam logic [REG_AW-1:0] OFF_DIV_HS  = 8'h18;
    localparam logic [REG_AW-1:0] OFF_TX_CFG  = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_RX_CFG  = 8'h20;
    localparam logic [REG_AW-1:0] OFF_DATA    = 8'h24;
    localparam logic [REG_AW-1:0] OFF_STATUS  = 8'h28;

    localparam int CB_MASTER = 0;
    localparam int CB_TEN    = 1;
    localparam int CB_IE     = 3;
    localparam int CB_READ   = 4;
    localparam int CB_COMB   = 5;
    localparam int CB_START  = 6;
    localparam int CB_ACTION = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } txn_state_t;

endpackage

// File: rtl/i2c_rf_fifo.sv
module i2c_rf_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW:0]      wr_ptr;
    logic [PW:0]      rd_ptr;
    logic [PW:0]      level;
    logic             do_push;
    logic             do_pop;

    assign level   = wr_ptr - rd_ptr;
    assign empty   = (level == '0);
    assign full    = (level == (PW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr[PW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[PW-1:0]] <= din;
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (PW+1)'(DEPTH));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    assert_full_drops_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

    assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);

endmodule

// File: rtl/i2c_rf_txn_fsm.sv
module i2c_rf_txn_fsm
    import i2c_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic evt_any,
    output logic eng_start,
    output logic active,
    output logic accept_evt
);
    txn_state_t state_q;
    txn_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch_req) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = evt_any ? ST_IDLE : ST_BUSY;
            ST_BUSY:   if (evt_any) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        eng_start  = 1'b0;
        active     = 1'b0;
        accept_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LAUNCH: begin
                eng_start  = 1'b1;
                active     = 1'b1;
                accept_evt = evt_any;
            end
            ST_BUSY: begin
                active     = 1'b1;
                accept_evt = evt_any;
            end
            default: ;
        endcase
    end

    assert_start_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_event_ends_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_evt |=> (state_q == ST_IDLE));

    assert_launch_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && !active) |=> eng_start);

endmodule

// File: rtl/i2c_reg_frontend.sv
module i2c_reg_frontend
    import i2c_rf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    bus_addr,
    input  logic                          bus_wr,
    input  logic [31:0]                   bus_wdata,
    input  logic                          bus_rd,
    output logic [31:0]                   bus_rdata,
    output logic                          irq,
    output logic                          eng_start,
    output logic                          eng_read,
    output logic                          eng_combined,
    output logic                          eng_ten_bit,
    output logic [9:0]                    eng_addr,
    output logic [DIV_W-1:0]              eng_div_fast,
    output logic [DIV_W-1:0]              eng_div_hs,
    output logic [$clog2(FIFO_DEPTH)-1:0] eng_rd_count,
    output logic [7:0]                    eng_tx_data,
    output logic                          eng_tx_empty,
    input  logic                          eng_tx_pop,
    input  logic [7:0]                    eng_rx_data,
    input  logic                          eng_rx_push,
    output logic                          eng_rx_full,
    input  logic                          eng_done,
    input  logic                          eng_nak_addr,
    input  logic                          eng_nak_data
);
    localparam int CNT_W = $clog2(FIFO_DEPTH);

    logic cmd_master, cmd_ten, cmd_ie, cmd_read, cmd_comb, cmd_start;
    logic [2:0]       addr_hi;
    logic [6:0]       addr_lo;
    logic [DIV_W-1:0] div_fs, div_hs;
    logic [CNT_W-1:0] tx_cfg, rx_cfg;
    logic [2:0]       status;

    logic wr_cmd, wr_ahi, wr_alo, wr_dfs, wr_dhs, wr_txc, wr_rxc, wr_data, wr_stat;
    logic rd_data;
    logic launch_req, evt_any, active, accept_evt;
    logic tx_flush, rx_flush, rx_empty, tx_full_unused;
    logic [7:0] rx_dout;
    logic [2:0] evt_vec;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_cmd  = bus_wr && (bus_addr == OFF_CMD);
    assign wr_ahi  = bus_wr && (bus_addr == OFF_ADDR_HI);
    assign wr_alo  = bus_wr && (bus_addr == OFF_ADDR_LO);
    assign wr_dfs  = bus_wr && (bus_addr == OFF_DIV_FS);
    assign wr_dhs  = bus_wr && (bus_addr == OFF_DIV_HS);
    assign wr_txc  = bus_wr && (bus_addr == OFF_TX_CFG);
    assign wr_rxc  = bus_wr && (bus_addr == OFF_RX_CFG);
    assign wr_data = bus_wr && (bus_addr == OFF_DATA);
    assign wr_stat = bus_wr && (bus_addr == OFF_STATUS);
    assign rd_data = bus_rd && (bus_addr == OFF_DATA);

    assign tx_flush = wr_txc && bus_wdata[CB_ACTION];
    assign rx_flush = wr_rxc && bus_wdata[CB_ACTION];

    assign launch_req = wr_cmd && bus_wdata[CB_START] && bus_wdata[CB_MASTER] && !active;
    assign evt_vec    = {eng_nak_data, eng_nak_addr, eng_done};
    assign evt_any    = |evt_vec;

    i2c_rf_txn_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (launch_req),
        .evt_any    (evt_any),
        .eng_start  (eng_start),
        .active     (active),
        .accept_evt (accept_evt)
    );

    i2c_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (wr_data),
        .din   (bus_wdata[7:0]),
        .pop   (eng_tx_pop),
        .dout  (eng_tx_data),
        .empty (eng_tx_empty),
        .full  (tx_full_unused)
    );

    i2c_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (eng_rx_push),
        .din   (eng_rx_data),
        .pop   (rd_data),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (eng_rx_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_master <= 1'b0;
            cmd_ten    <= 1'b0;
            cmd_ie     <= 1'b0;
            cmd_read   <= 1'b0;
            cmd_comb   <= 1'b0;
        end else if (wr_cmd) begin
            cmd_master <= bus_wdata[CB_MASTER];
            cmd_ten    <= bus_wdata[CB_TEN];
            cmd_ie     <= bus_wdata[CB_IE];
            cmd_read   <= bus_wdata[CB_READ];
            cmd_comb   <= bus_wdata[CB_COMB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cmd_start <= 1'b0;
        else if (accept_evt) cmd_start <= 1'b0;
        else if (launch_req) cmd_start <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi <= '0;
            addr_lo <= '0;
            div_fs  <= '0;
            div_hs  <= '0;
            tx_cfg  <= '0;
            rx_cfg  <= '0;
        end else begin
            if (wr_ahi) addr_hi <= bus_wdata[2:0];
            if (wr_alo) addr_lo <= bus_wdata[6:0];
            if (wr_dfs) div_fs  <= bus_wdata[DIV_W-1:0];
            if (wr_dhs) div_hs  <= bus_wdata[DIV_W-1:0];
            if (wr_txc) tx_cfg  <= bus_wdata[CNT_W-1:0];
            if (wr_rxc) rx_cfg  <= bus_wdata[CNT_W-1:0];
        end
    end

    generate
        for (genvar i = 0; i < 3; i++) begin : g_status
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              status[i] <= 1'b0;
                else if (accept_evt && evt_vec[i])       status[i] <= 1'b1;
                else if (wr_stat && bus_wdata[CB_ACTION]) status[i] <= 1'b0;
            end
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CMD: begin
                bus_rdata[CB_MASTER] = cmd_master;
                bus_rdata[CB_TEN]    = cmd_ten;
                bus_rdata[CB_IE]     = cmd_ie;
                bus_rdata[CB_READ]   = cmd_read;
                bus_rdata[CB_COMB]   = cmd_comb;
                bus_rdata[CB_START]  = cmd_start;
            end
            OFF_ADDR_HI: bus_rdata[2:0]       = addr_hi;
            OFF_ADDR_LO: bus_rdata[6:0]       = addr_lo;
            OFF_DIV_FS:  bus_rdata[DIV_W-1:0] = div_fs;
            OFF_DIV_HS:  bus_rdata[DIV_W-1:0] = div_hs;
            OFF_TX_CFG:  bus_rdata[CNT_W-1:0] = tx_cfg;
            OFF_RX_CFG:  bus_rdata[CNT_W-1:0] = rx_cfg;
            OFF_DATA:    bus_rdata[7:0]       = rx_empty ? 8'h00 : rx_dout;
            OFF_STATUS:  bus_rdata[2:0]       = status;
            default:     bus_rdata            = '0;
        endcase
    end

    assign irq          = cmd_ie && (|status);
    assign eng_read     = cmd_read;
    assign eng_combined = cmd_comb;
    assign eng_ten_bit  = cmd_ten;
    assign eng_addr     = {addr_hi, addr_lo};
    assign eng_div_fast = div_fs;
    assign eng_div_hs   = div_hs;
    assign eng_rd_count = rx_cfg;

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[CB_ACTION] && !accept_evt) |=> (status == 3'b000));

    assert_event_clears_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_evt |=> !cmd_start);

    assert_idle_event_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(wr_stat && bus_wdata[CB_ACTION])) |=> $stable(status));

endmodule

// File: tb/i2c_reg_frontend_tb.sv
module i2c_reg_frontend_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_read, eng_combined, eng_ten_bit;
    logic [9:0]  eng_addr;
    logic [15:0] eng_div_fast, eng_div_hs;
    logic [3:0]  eng_rd_count;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_empty;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_push = 1'b0;
    logic        eng_rx_full;
    logic        eng_done = 1'b0, eng_nak_addr = 1'b0, eng_nak_data = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    i2c_reg_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
        .eng_start(eng_start), .eng_read(eng_read), .eng_combined(eng_combined),
        .eng_ten_bit(eng_ten_bit), .eng_addr(eng_addr), .eng_div_fast(eng_div_fast),
        .eng_div_hs(eng_div_hs), .eng_rd_count(eng_rd_count), .eng_tx_data(eng_tx_data),
        .eng_tx_empty(eng_tx_empty), .eng_tx_pop(eng_tx_pop), .eng_rx_data(eng_rx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_full(eng_rx_full), .eng_done(eng_done),
        .eng_nak_addr(eng_nak_addr), .eng_nak_data(eng_nak_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_data = b; eng_rx_push = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        #1;
        check(req, {24'd0, eng_tx_data}, {24'd0, exp});
        eng_tx_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        @(negedge clk);
        {eng_nak_data, eng_nak_addr, eng_done} = e;
        @(posedge clk);
        @(negedge clk);
        {eng_nak_data, eng_nak_addr, eng_done} = 3'b000;
        #1;
    endtask

    task automatic t_reset;
        rd_chk("R1 cmd", 8'h04, 0);
        rd_chk("R1 addr_lo", 8'h10, 0);
        rd_chk("R1 div_fs", 8'h14, 0);
        rd_chk("R1 rx_cfg", 8'h20, 0);
        rd_chk("R1 status", 8'h28, 0);
        rd_chk("R1 data", 8'h24, 0);
        check("R1 irq", irq, 0);
        check("R1 eng_start", eng_start, 0);
        check("R1 tx_empty", eng_tx_empty, 1);
        check("R1 rx_full", eng_rx_full, 0);
    endtask

    task automatic t_regmap;
        wr(8'h04, 32'h0000_00BB);
        rd_chk("R2 cmd mask", 8'h04, 32'h3B);
        check("R11 ten", eng_ten_bit, 1);
        check("R11 read", eng_read, 1);
        check("R11 comb", eng_combined, 1);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFD);
        rd_chk("R2 addr_lo", 8'h10, 32'h7F);
        rd_chk("R2 addr_hi", 8'h0C, 32'h5);
        check("R2 eng_addr", eng_addr, 10'h2FF);
        wr(8'h14, 32'h1234_5678);
        wr(8'h18, 32'hABCD_9876);
        rd_chk("R2 div_fs", 8'h14, 32'h5678);
        check("R2 eng_div_fast", eng_div_fast, 16'h5678);
        check("R2 eng_div_hs", eng_div_hs, 16'h9876);
        rd_chk("R2 unmapped", 8'h08, 0);
        wr(8'h04, 32'h0000_0001);
        check("R11 read off", eng_read, 0);
        check("R11 ten off", eng_ten_bit, 0);
    endtask

    task automatic t_tx;
        for (int i = 0; i < 17; i++) wr(8'h24, 32'hFF00_00A0 + i);
        check("R3 not empty", eng_tx_empty, 0);
        for (int i = 0; i < 16; i++) tx_pop_chk("R3 order", 8'hA0 + 8'(i));
        #1;
        check("R3 overflow dropped", eng_tx_empty, 1);
    endtask

    task automatic t_rx;
        rd_chk("R4 empty read", 8'h24, 0);
        for (int i = 0; i < 16; i++) rx_push(8'h30 + 8'(i));
        #1;
        check("R4 full", eng_rx_full, 1);
        rx_push(8'hEE);
        for (int i = 0; i < 16; i++) rd_chk("R4 order", 8'h24, 32'h30 + i);
        rd_chk("R4 empty after drain", 8'h24, 0);
        rx_push(8'h5A);
        rd_chk("R4 pointers kept", 8'h24, 32'h5A);
        rd_chk("R4 empty again", 8'h24, 0);
    endtask

    task automatic t_flush;
        wr(8'h24, 32'h11); wr(8'h24, 32'h22); wr(8'h24, 32'h33);
        wr(8'h1C, 32'h8A);
        check("R5 tx flushed", eng_tx_empty, 1);
        rd_chk("R5 tx_cfg kept", 8'h1C, 32'hA);
        rx_push(8'h44); rx_push(8'h55);
        wr(8'h20, 32'h85);
        rd_chk("R5 rx_cfg kept", 8'h20, 32'h5);
        check("R6 rd_count", eng_rd_count, 4'h5);
        rd_chk("R5 rx flushed", 8'h24, 0);
        wr(8'h20, 32'h0F);
        check("R6 rd_count max", eng_rd_count, 4'hF);
    endtask

    task automatic t_txn;
        wr(8'h04, 32'h48);
        check("R7 no start without enable", eng_start, 0);
        rd_chk("R7 start not stored", 8'h04, 32'h08);
        pulse_evt(3'b010);
        rd_chk("R8 idle event ignored", 8'h28, 0);
        wr(8'h04, 32'h49);
        check("R7 start pulse", eng_start, 1);
        @(negedge clk); #1;
        check("R7 pulse one cycle", eng_start, 0);
        rd_chk("R7 start bit held", 8'h04, 32'h49);
        check("R10 irq before event", irq, 0);
        pulse_evt(3'b001);
        rd_chk("R8 done flag", 8'h28, 32'h1);
        rd_chk("R8 start cleared", 8'h04, 32'h09);
        check("R10 irq set", irq, 1);
        wr(8'h28, 32'h80);
        rd_chk("R9 ack clears", 8'h28, 0);
        check("R10 irq cleared", irq, 0);
        wr(8'h04, 32'h41);
        pulse_evt(3'b100);
        rd_chk("R8 nak data flag", 8'h28, 32'h4);
        check("R10 irq masked", irq, 0);
        wr(8'h28, 32'h80);
        wr(8'h04, 32'h49);
        @(negedge clk);
        bus_addr = 8'h28; bus_wdata = 32'h80; bus_wr = 1'b1; eng_nak_addr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; eng_nak_addr = 1'b0;
        rd_chk("R9 event wins over ack", 8'h28, 32'h2);
        rd_chk("R8 nak addr ends txn", 8'h04, 32'h09);
        check("R10 irq nak addr", irq, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_tx;
        t_rx;
        t_flush;
        t_txn;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule